// File: doc/BRIEF.md
# Self-Detecting Multiplexed Bus Write Port

This block lets an 8-bit processor with a multiplexed address/data bus write a small bank of byte registers. It works with either of the two usual strobe styles, and no strap pin picks the style. In the split style the control lines are an address-latch enable, an active-low write strobe and an active-low read strobe. In the shared style they are an address strobe, an active-high data strobe and a read/write line. A chip-select input lets other peripherals share the bus. The registers can only be written; nothing is ever driven back onto the bus.

On every rising edge of the address strobe, the block records the level of the strobe pin that both styles share. A high level selects the split style and a low level selects the shared style. Because this happens on every bus cycle, masters of different styles may alternate on the same wires. The address comes off the shared lines when the address strobe falls. The data byte is written either when the write strobe rises (split style) or when the data strobe falls with read/write low (shared style). Chip select must be low in both cases. All bus pins pass through a two-stage synchroniser into the system clock. Every decision is then taken on the synchronised levels.

Top module: `mbus_write_if`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears to 0x00 and every write pulse is low.
- R2: A high level on `bus_ds_rd` at the rising edge of `bus_as` selects the split style. A low level selects the shared style.
- R3: The style is chosen again on every address strobe, so split-style and shared-style cycles may follow each other with no other action.
- R4: The register index is taken from `bus_ad` at the falling edge of `bus_as`. Later values on `bus_ad` are used only as data.
- R5: In the split style, a rising edge of `bus_wr_rw` with `bus_cs_n` low writes `bus_ad` into the addressed register.
- R6: In the split style, a pulse on `bus_ds_rd` (a read) never writes a register.
- R7: In the shared style, a falling edge of `bus_ds_rd` with `bus_wr_rw` low and `bus_cs_n` low writes `bus_ad` into the addressed register.
- R8: In the shared style, a data-strobe cycle with `bus_wr_rw` high (a read) never writes a register.
- R9: With `bus_cs_n` high at the write edge, no register is written in either style.
- R10: A latched address equal to or above `NUM_REGS` (8 by default) writes nothing.
- R11: A valid write raises exactly one bit of `reg_wr_stb`, namely the bit of the written register. It is high for one clock cycle, in the cycle after the third rising clock edge that follows the bus write edge.
- R12: A register whose write pulse is low keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ad | input | 8 | Multiplexed address/data lines |
| bus_as | input | 1 | Address-latch enable / address strobe, active high |
| bus_ds_rd | input | 1 | Active-low read strobe (split style) or active-high data strobe (shared style) |
| bus_wr_rw | input | 1 | Active-low write strobe (split style) or read/write, low for write (shared style) |
| bus_cs_n | input | 1 | Chip select, active low |
| reg_q | output | NUM_REGS*8 | Register contents; register i is bits [8i+7:8i] |
| reg_wr_stb | output | NUM_REGS | One-cycle pulse, bit i marks a write to register i |

## Verification
Each bus edge passes two synchroniser flops. The edge is then decoded in the next cycle. This puts a register update and its pulse three rising clock edges after the pin edge, and the latched style and address follow the same rule. The bench drives the bus only on falling clock edges and holds every bus phase for at least three cycles. It numbers each falling-edge sample and records the index of any pulse seen. Every write must then show its pulse exactly three samples after the write edge, and no pulse anywhere else in the bus cycle. Cases that must write nothing are checked by seeing no pulse at all over the whole cycle, and by reading back all register values afterwards.

// File: rtl/mbus_pkg.sv
// Shared definitions for the multiplexed bus write port.
// Assumes an 8-bit multiplexed bus; address and data share the same lines.
package mbus_pkg;

    localparam int BUS_W = 8;

    // Bus style recorded at each address strobe.
    typedef enum logic {
        STYLE_SPLIT  = 1'b0,   // separate read and write strobes
        STYLE_SHARED = 1'b1    // one data strobe plus a read/write line
    } bus_style_e;

endpackage

// File: rtl/mbus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous bus pins.
// Assumes the bus holds every bit stable for several clocks around the
// edges that matter, so bits of one vector stay aligned after sampling.
module mbus_sync #(
    parameter int             W       = 12,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    // Shift the pin levels through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mbus_decode.sv
// Decodes the synchronised bus levels. It records the bus style at each
// address strobe rise and the address at each fall. It then qualifies
// write edges for the style in force.
// Assumes no write edge falls in the same clock as an address strobe edge.
module mbus_decode
    import mbus_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter int         IDX_W       = 3,
    parameter bus_style_e RESET_STYLE = STYLE_SPLIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] ad,
    input  logic             as_lvl,
    input  logic             ds_lvl,
    input  logic             wr_lvl,
    input  logic             cs_n_lvl,
    output logic             wr_req,
    output logic [IDX_W-1:0] wr_idx,
    output logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] lat_addr
);

    logic       as_q, ds_q, wr_q;
    logic       as_rise, as_fall, ds_fall, wr_rise;
    logic       in_range, split_hit, shared_hit;
    bus_style_e style;

    // Previous synchronised levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_q <= 1'b0;
            ds_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            as_q <= as_lvl;
            ds_q <= ds_lvl;
            wr_q <= wr_lvl;
        end
    end

    // Edge flags on the synchronised control lines.
    always_comb begin
        as_rise = as_lvl & ~as_q;
        as_fall = ~as_lvl & as_q;
        ds_fall = ~ds_lvl & ds_q;
        wr_rise = wr_lvl & ~wr_q;
    end

    // Record the bus style on every address strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       style <= RESET_STYLE;
        else if (as_rise) style <= ds_lvl ? STYLE_SPLIT : STYLE_SHARED;
    end

    // Latch the address on every address strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_addr <= '0;
        else if (as_fall) lat_addr <= ad;
    end

    // Qualify a write for the current style, chip select and address range.
    always_comb begin
        in_range   = (lat_addr < BUS_W'(NUM_REGS));
        split_hit  = (style == STYLE_SPLIT)  && wr_rise && !cs_n_lvl;
        shared_hit = (style == STYLE_SHARED) && ds_fall && !wr_lvl && !cs_n_lvl;
        wr_req     = in_range && (split_hit || shared_hit);
        wr_idx     = lat_addr[IDX_W-1:0];
        wr_data    = ad;
    end

endmodule

// File: rtl/mbus_regfile.sv
// Bank of byte registers with one write pulse per register.
// Assumes at most one write request per clock and an index already range-checked.
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_req,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [BUS_W-1:0]          wr_data,
    output logic [NUM_REGS*BUS_W-1:0] reg_q,
    output logic [NUM_REGS-1:0]       reg_wr_stb
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign hit = wr_req && (wr_idx == IDX_W'(i));

        // Store the byte for register i and pulse its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q[i*BUS_W +: BUS_W] <= '0;
                reg_wr_stb[i]           <= 1'b0;
            end else begin
                reg_wr_stb[i] <= hit;
                if (hit) reg_q[i*BUS_W +: BUS_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mbus_write_if.sv
// Top level: write-only register port for an 8-bit multiplexed bus that
// detects its strobe style by itself on every address strobe.
// Assumes bus phases last at least three clock cycles. A write lands
// three rising clock edges after its bus edge.
module mbus_write_if
    import mbus_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                bus_ad,
    input  logic                      bus_as,
    input  logic                      bus_ds_rd,
    input  logic                      bus_wr_rw,
    input  logic                      bus_cs_n,
    output logic [NUM_REGS*8-1:0]     reg_q,
    output logic [NUM_REGS-1:0]       reg_wr_stb
);

    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int SYNC_W = BUS_W + 4;
    localparam logic [SYNC_W-1:0] SYNC_IDLE = {{BUS_W{1'b0}}, 4'b0111};

    logic [SYNC_W-1:0] pins_raw, pins_s;
    logic [BUS_W-1:0]  ad_s;
    logic              as_s, ds_s, wr_s, cs_n_s;
    logic              wr_req;
    logic [IDX_W-1:0]  wr_idx;
    logic [BUS_W-1:0]  wr_data;
    logic [BUS_W-1:0]  lat_addr;

    assign pins_raw = {bus_ad, bus_as, bus_ds_rd, bus_wr_rw, bus_cs_n};
    assign {ad_s, as_s, ds_s, wr_s, cs_n_s} = pins_s;

    mbus_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins_raw),
        .q     (pins_s)
    );

    mbus_decode #(
        .NUM_REGS    (NUM_REGS),
        .IDX_W       (IDX_W),
        .RESET_STYLE (STYLE_SPLIT)
    ) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ad       (ad_s),
        .as_lvl   (as_s),
        .ds_lvl   (ds_s),
        .wr_lvl   (wr_s),
        .cs_n_lvl (cs_n_s),
        .wr_req   (wr_req),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .lat_addr (lat_addr)
    );

    mbus_regfile #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .reg_q      (reg_q),
        .reg_wr_stb (reg_wr_stb)
    );

endmodule

// File: rtl/mbus_write_if_chk.sv
// Property checker for mbus_write_if, attached with bind below.
// It watches the register outputs against the decoder's request and latched address.
module mbus_write_if_chk #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_REGS*8-1:0] reg_q,
    input logic [NUM_REGS-1:0]   reg_wr_stb,
    input logic                  wr_req,
    input logic [7:0]            lat_addr
);

    // R1: reset clears registers and pulses
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_q == '0 && reg_wr_stb == '0));

    // R11: at most one pulse bit at a time
    assert_stb_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_wr_stb));

    // R11: a pulse lasts a single cycle
    assert_stb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_wr_stb) |=> !(|reg_wr_stb));

    // R11: each decoded request yields a pulse in the next cycle
    assert_req_to_stb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (|reg_wr_stb));

    // R10: a pulse only appears for an in-range latched address, on its own bit
    assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_wr_stb) |-> ($past(lat_addr) < 8'(NUM_REGS)
                           && reg_wr_stb[$past(lat_addr[IDX_W-1:0])]));

    // R12: a register without a pulse keeps its value
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hold
        assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_wr_stb[i] |-> $stable(reg_q[i*8 +: 8]));
    end

endmodule

bind mbus_write_if mbus_write_if_chk #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_q      (reg_q),
    .reg_wr_stb (reg_wr_stb),
    .wr_req     (wr_req),
    .lat_addr   (lat_addr)
);

// File: tb/test_mbus_write_if.sv
// Directed bench for mbus_write_if: one task per scenario.
module test_mbus_write_if;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     bus_ad = 8'h00;
    logic           bus_as = 1'b0;
    logic           bus_ds_rd = 1'b1;
    logic           bus_wr_rw = 1'b1;
    logic           bus_cs_n = 1'b1;
    logic [N*8-1:0] reg_q;
    logic [N-1:0]   reg_wr_stb;

    int         n_chk = 0;
    int         n_bad = 0;
    int         tick_no = 0;
    int         hits = 0;
    int         hit_tick = -1;
    logic [N-1:0] hit_stb = '0;
    logic [7:0] exp_regs [N];

    mbus_write_if #(.NUM_REGS(N)) i_mbus_write_if (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_ad     (bus_ad),
        .bus_as     (bus_as),
        .bus_ds_rd  (bus_ds_rd),
        .bus_wr_rw  (bus_wr_rw),
        .bus_cs_n   (bus_cs_n),
        .reg_q      (reg_q),
        .reg_wr_stb (reg_wr_stb)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock; samples outputs at the falling edge and logs pulses.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        tick_no++;
        if (|reg_wr_stb) begin
            hits++;
            hit_tick = tick_no;
            hit_stb  = reg_wr_stb;
        end
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    // Full bus cycle; lat = samples from write edge to pulse, -1 if none.
    task automatic run_cycle(input bit shared, input logic [7:0] addr,
                             input logic [7:0] data, input bit cs_off,
                             input bit is_read, output int lat);
        int edge_t;
        hits = 0;
        hit_tick = -1;
        hit_stb = '0;
        bus_as    = 1'b0;
        bus_ds_rd = shared ? 1'b0 : 1'b1;
        bus_wr_rw = shared ? is_read : 1'b1;
        bus_cs_n  = cs_off;
        bus_ad    = addr;
        wait_n(3);
        bus_as = 1'b1;
        wait_n(4);
        bus_as = 1'b0;
        wait_n(4);
        bus_ad = data;
        wait_n(3);
        if (shared) begin
            bus_ds_rd = 1'b1;
            wait_n(4);
            bus_ds_rd = 1'b0;
        end else if (!is_read) begin
            bus_wr_rw = 1'b0;
            wait_n(4);
            bus_wr_rw = 1'b1;
        end else begin
            bus_ds_rd = 1'b0;
            wait_n(4);
            bus_ds_rd = 1'b1;
        end
        edge_t = tick_no;
        wait_n(6);
        lat = (hits > 0) ? hit_tick - edge_t : -1;
        bus_cs_n = 1'b1;
        wait_n(3);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < N; i++)
            chk(reg_q[i*8 +: 8] == exp_regs[i], req, $sformatf("reg%0d", i),
                64'(reg_q[i*8 +: 8]), 64'(exp_regs[i]));
    endtask

    // A write that must land: one pulse, right bit, three samples late.
    task automatic write_ok(input bit shared, input logic [7:0] addr,
                            input logic [7:0] data, input string req);
        int lat;
        run_cycle(shared, addr, data, 1'b0, 1'b0, lat);
        chk(hits == 1, req, "pulse count", 64'(hits), 64'd1);
        chk(lat == 3, "R11", "pulse latency", 64'(lat), 64'd3);
        chk(hit_stb == N'(1) << addr[2:0], "R11", "pulse bit",
            64'(hit_stb), 64'(N'(1) << addr[2:0]));
        exp_regs[addr[2:0]] = data;
        check_regs({req, "/R12"});
    endtask

    // A cycle that must write nothing.
    task automatic write_none(input bit shared, input logic [7:0] addr,
                              input logic [7:0] data, input bit cs_off,
                              input bit is_read, input string req);
        int lat;
        run_cycle(shared, addr, data, cs_off, is_read, lat);
        chk(hits == 0, req, "unexpected pulse", 64'(hits), 64'd0);
        check_regs(req);
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) exp_regs[i] = 8'h00;
        chk(reg_q == '0, "R1", "regs after reset", reg_q, 64'd0);
        chk(reg_wr_stb == '0, "R1", "pulses after reset", 64'(reg_wr_stb), 64'd0);
    endtask

    task automatic t_split_write();   // R5, R2
        write_ok(1'b0, 8'd2, 8'hA5, "R5");
        write_ok(1'b0, 8'd7, 8'h3C, "R5");
        write_ok(1'b0, 8'd0, 8'hFF, "R2");
    endtask

    task automatic t_shared_write();  // R7, R2
        write_ok(1'b1, 8'd5, 8'h81, "R7");
        write_ok(1'b1, 8'd1, 8'h5A, "R2");
    endtask

    task automatic t_alternate();     // R3
        write_ok(1'b0, 8'd4, 8'h11, "R3");
        write_ok(1'b1, 8'd4, 8'h22, "R3");
        write_ok(1'b0, 8'd6, 8'h33, "R3");
        write_ok(1'b1, 8'd6, 8'h44, "R3");
    endtask

    task automatic t_addr_latch();    // R4: data byte differs from the address
        write_ok(1'b0, 8'd3, 8'h05, "R4");
        write_ok(1'b1, 8'd1, 8'h06, "R4");
    endtask

    task automatic t_reads();
        write_none(1'b0, 8'd2, 8'h77, 1'b0, 1'b1, "R6");
        write_none(1'b1, 8'd5, 8'h66, 1'b0, 1'b1, "R8");
    endtask

    task automatic t_chip_select();   // R9
        write_none(1'b0, 8'd3, 8'h99, 1'b1, 1'b0, "R9");
        write_none(1'b1, 8'd3, 8'h98, 1'b1, 1'b0, "R9");
    endtask

    task automatic t_range();         // R10
        write_none(1'b0, 8'd8,  8'hEE, 1'b0, 1'b0, "R10");
        write_none(1'b1, 8'hFF, 8'hDD, 1'b0, 1'b0, "R10");
        write_none(1'b1, 8'h0A, 8'hCC, 1'b0, 1'b0, "R10");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_split_write();
        t_shared_write();
        t_alternate();
        t_addr_latch();
        t_reads();
        t_chip_select();
        t_range();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule